// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block gives one processor core a two-word command register through which it sends an interrupt message to other cores. Software first stores the target core number in the upper command word. It then writes the lower command word, which holds the vector, delivery type, trigger mode, level and destination shorthand. The lower-word write is the send: the unit captures the command and presents it on an outbound message port with a valid/ready handshake.

The unit reports a busy flag inside the lower word for as long as the message is waiting on the port. Software polls that flag and issues the next command only after it clears. A lower-word write that arrives while a message is still pending is dropped. The unit also turns the shorthand into a per-core destination mask for a small, fixed number of cores, so the fabric that routes the message does not have to decode the shorthand itself.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, msg_valid_o is 0 and reads of the lower word (offset 0x300) and of the upper word (offset 0x310) return 0.
- R2: A write to offset 0x310 stores all 32 bits, and a later read of 0x310 returns them. Bits 31:24 of that word are the destination core number that the next launch carries on msg_dest_id_o.
- R3: A write to offset 0x300 while the unit is idle launches a message, and msg_valid_o is 1 in the following cycle. The port then carries these fields of the written word: vector in bits 7:0, delivery mode in bits 10:8 (000 fixed, 101 INIT, 110 startup), level in bit 14 (1 assert, 0 deassert), trigger in bit 15 (1 level) and shorthand in bits 19:18.
- R4: Bit 12 of the lower word reads 1 from the cycle after a launch until the cycle after the clock edge at which msg_valid_o and msg_ready_i are both 1. It then reads 0, and msg_valid_o falls at the same time.
- R5: While msg_valid_o is 1 and msg_ready_i is 0, every message field and the destination mask hold their values.
- R6: A write to 0x300 while bit 12 reads 1 has no effect. The pending message is unchanged, and no second message follows the handshake.
- R7: With shorthand 00, the mask has exactly the bit of the core numbered by the destination field set, or no bit at all when that number is not below NUM_CORES.
- R8: With shorthand 01, the mask holds only the bit of this core (CORE_ID).
- R9: With shorthand 10, every mask bit is set.
- R10: With shorthand 11, every mask bit is set except this core's bit.
- R11: A read of 0x300 returns the fields of the last launched command in their write positions, plus bit 12. Bits 17:16 (remote read status) read 00, meaning invalid, and all other bits read 0.
- R12: Reads of any other offset return 0, and writes to any other offset change neither command word nor the message port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| msg_valid_o | output | 1 | Message pending on the port |
| msg_ready_i | input | 1 | Port accepts the message |
| msg_vector_o | output | 8 | Vector |
| msg_mode_o | output | 3 | Delivery mode |
| msg_trig_o | output | 1 | Trigger mode, 1 = level |
| msg_level_o | output | 1 | Level, 1 = assert |
| msg_short_o | output | 2 | Destination shorthand |
| msg_dest_id_o | output | 8 | Destination core number |
| msg_dest_mask_o | output | NUM_CORES | Resolved per-core destination mask |

## Verification
Each result of a lower-word write is due in the cycle after the clock edge that sampled the write: the port fields, msg_valid_o and busy bit 12. Busy clears in the cycle after the edge that sees valid and ready together. Register reads are combinational, so they settle in the same cycle the offset is presented. The bench therefore changes inputs at the falling edge and samples at the next falling edge, exactly one register stage after the stimulus. Random commands run through full launch, hold and handshake sequences, mixed with directed cases for startup, INIT and each shorthand.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned REG_DW = 32;
  localparam logic [REG_AW-1:0] OFF_CMD_LO = 12'h300;
  localparam logic [REG_AW-1:0] OFF_CMD_HI = 12'h310;

  // lower word bit positions
  localparam int unsigned VEC_LSB   = 0;
  localparam int unsigned MODE_LSB  = 8;
  localparam int unsigned BUSY_BIT  = 12;
  localparam int unsigned LEVEL_BIT = 14;
  localparam int unsigned TRIG_BIT  = 15;
  localparam int unsigned SH_LSB    = 18;
  localparam int unsigned DEST_LSB  = 24;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  typedef struct packed {
    shorthand_e  sh;
    logic        trig;
    logic        level;
    logic [2:0]  mode;
    logic [7:0]  vector;
  } cmd_lo_t;
endpackage

// File: rtl/ipi_reg_decode.sv
module ipi_reg_decode
  import ipi_pkg::*;
(
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  output logic              sel_lo_o,
  output logic              sel_hi_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o
);
  assign sel_lo_o = (addr_i == OFF_CMD_LO);
  assign sel_hi_o = (addr_i == OFF_CMD_HI);
  assign wr_lo_o  = wr_i && sel_lo_o;
  assign wr_hi_o  = wr_i && sel_hi_o;
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
  import ipi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_lo_i,
  input  cmd_lo_t    cmd_i,
  input  logic [7:0] dest_i,
  input  logic       ready_i,
  output logic       busy_o,
  output cmd_lo_t    cmd_o,
  output logic [7:0] dest_o
);
  logic launch;
  assign launch = wr_lo_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cmd_o  <= '0;
      dest_o <= '0;
    end else if (launch) begin
      busy_o <= 1'b1;
      cmd_o  <= cmd_i;
      dest_o <= dest_i;
    end else if (busy_o && ready_i) begin
      busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_ID   = 0
) (
  input  shorthand_e           sh_i,
  input  logic [7:0]           dest_id_i,
  output logic [NUM_CORES-1:0] mask_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    localparam bit IS_SELF = (c == CORE_ID);
    always_comb begin
      unique case (sh_i)
        SH_FIELD:  mask_o[c] = (dest_id_i == 8'(c));
        SH_SELF:   mask_o[c] = IS_SELF;
        SH_ALL:    mask_o[c] = 1'b1;
        default:   mask_o[c] = !IS_SELF;
      endcase
    end
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_ID   = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic [11:0]          reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [7:0]           msg_vector_o,
  output logic [2:0]           msg_mode_o,
  output logic                 msg_trig_o,
  output logic                 msg_level_o,
  output logic [1:0]           msg_short_o,
  output logic [7:0]           msg_dest_id_o,
  output logic [NUM_CORES-1:0] msg_dest_mask_o
);
  logic        sel_lo, sel_hi, wr_lo, wr_hi, busy;
  logic [31:0] hi_q;
  cmd_lo_t     wr_cmd, cur_cmd;
  logic [31:0] lo_view;

  ipi_reg_decode u_dec (
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .sel_lo_o(sel_lo),
    .sel_hi_o(sel_hi),
    .wr_lo_o (wr_lo),
    .wr_hi_o (wr_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (wr_hi) hi_q <= reg_wdata_i;
  end

  assign wr_cmd.vector = reg_wdata_i[VEC_LSB +: 8];
  assign wr_cmd.mode   = reg_wdata_i[MODE_LSB +: 3];
  assign wr_cmd.level  = reg_wdata_i[LEVEL_BIT];
  assign wr_cmd.trig   = reg_wdata_i[TRIG_BIT];
  assign wr_cmd.sh     = shorthand_e'(reg_wdata_i[SH_LSB +: 2]);

  ipi_launch u_launch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_lo_i(wr_lo),
    .cmd_i  (wr_cmd),
    .dest_i (hi_q[DEST_LSB +: 8]),
    .ready_i(msg_ready_i),
    .busy_o (busy),
    .cmd_o  (cur_cmd),
    .dest_o (msg_dest_id_o)
  );

  ipi_dest_resolve #(.NUM_CORES(NUM_CORES), .CORE_ID(CORE_ID)) u_res (
    .sh_i     (cur_cmd.sh),
    .dest_id_i(msg_dest_id_o),
    .mask_o   (msg_dest_mask_o)
  );

  // remote read status (17:16) always reads invalid
  always_comb begin
    lo_view                     = '0;
    lo_view[VEC_LSB +: 8]       = cur_cmd.vector;
    lo_view[MODE_LSB +: 3]      = cur_cmd.mode;
    lo_view[BUSY_BIT]           = busy;
    lo_view[LEVEL_BIT]          = cur_cmd.level;
    lo_view[TRIG_BIT]           = cur_cmd.trig;
    lo_view[SH_LSB +: 2]        = cur_cmd.sh;
  end

  assign reg_rdata_o  = sel_lo ? lo_view : (sel_hi ? hi_q : '0);
  assign msg_valid_o  = busy;
  assign msg_vector_o = cur_cmd.vector;
  assign msg_mode_o   = cur_cmd.mode;
  assign msg_trig_o   = cur_cmd.trig;
  assign msg_level_o  = cur_cmd.level;
  assign msg_short_o  = cur_cmd.sh;
endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_ID   = 0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_wr_i,
  input logic [11:0]          reg_addr_i,
  input logic                 msg_valid_o,
  input logic                 msg_ready_i,
  input logic [7:0]           msg_vector_o,
  input logic [2:0]           msg_mode_o,
  input logic                 msg_trig_o,
  input logic                 msg_level_o,
  input logic [1:0]           msg_short_o,
  input logic [7:0]           msg_dest_id_o,
  input logic [NUM_CORES-1:0] msg_dest_mask_o
);
  localparam logic [NUM_CORES-1:0] SELF_BIT = NUM_CORES'(1) << CORE_ID;

  // R3
  launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 12'h300 && !msg_valid_o) |=> msg_valid_o);

  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> msg_valid_o);

  // R4
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_ready_i) |=> !msg_valid_o);

  // R5
  fields_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> ($stable(msg_vector_o) && $stable(msg_mode_o)
      && $stable(msg_trig_o) && $stable(msg_level_o) && $stable(msg_short_o)
      && $stable(msg_dest_id_o) && $stable(msg_dest_mask_o)));

  // R7
  field_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_short_o == 2'b00) |-> $onehot0(msg_dest_mask_o));

  // R8
  self_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_short_o == 2'b01) |-> msg_dest_mask_o == SELF_BIT);

  // R10
  others_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_short_o == 2'b11) |->
      ($countones(msg_dest_mask_o) == NUM_CORES - 1 && (msg_dest_mask_o & SELF_BIT) == '0));
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(.NUM_CORES(NUM_CORES), .CORE_ID(CORE_ID)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_wr_i       (reg_wr_i),
  .reg_addr_i     (reg_addr_i),
  .msg_valid_o    (msg_valid_o),
  .msg_ready_i    (msg_ready_i),
  .msg_vector_o   (msg_vector_o),
  .msg_mode_o     (msg_mode_o),
  .msg_trig_o     (msg_trig_o),
  .msg_level_o    (msg_level_o),
  .msg_short_o    (msg_short_o),
  .msg_dest_id_o  (msg_dest_id_o),
  .msg_dest_mask_o(msg_dest_mask_o)
);

// File: tb/ipi_cmd_unit_tb.sv
module ipi_cmd_unit_tb_top;
  localparam int NC  = 4;
  localparam int CID = 2;
  localparam logic [11:0] A_LO = 12'h300;
  localparam logic [11:0] A_HI = 12'h310;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [11:0]   addr = 12'h000;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          valid;
  logic          ready = 1'b0;
  logic [7:0]    vec;
  logic [2:0]    mode;
  logic          trig, level;
  logic [1:0]    sh;
  logic [7:0]    did;
  logic [NC-1:0] mask;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ipi_cmd_unit #(.NUM_CORES(NC), .CORE_ID(CID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .msg_valid_o(valid),
    .msg_ready_i(ready), .msg_vector_o(vec), .msg_mode_o(mode),
    .msg_trig_o(trig), .msg_level_o(level), .msg_short_o(sh),
    .msg_dest_id_o(did), .msg_dest_mask_o(mask)
  );

  task automatic report();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_mask(input logic [1:0] s, input logic [7:0] d);
    logic [NC-1:0] m = '0;
    for (int c = 0; c < NC; c++) begin
      case (s)
        2'b00: m[c] = (d == 8'(c));
        2'b01: m[c] = (c == CID);
        2'b10: m[c] = 1'b1;
        default: m[c] = (c != CID);
      endcase
    end
    return m;
  endfunction

  function automatic logic [31:0] exp_lo(input logic [31:0] w, input logic b);
    return (w & 32'h000C_C7FF) | (32'(b) << 12);
  endfunction

  function automatic logic [31:0] port_word();
    return {12'h0, sh, 2'b00, trig, level, 1'b0, valid, 1'b0, mode, vec};
  endfunction

  task automatic write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 12'h000;
  endtask

  task automatic read(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
    addr = 12'h000;
  endtask

  task automatic handshake();
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  // launches one command and checks everything due in the next cycle
  task automatic send_check(input logic [31:0] hi, input logic [31:0] lo, input string req);
    logic [31:0] r;
    write(A_HI, hi);
    read(A_HI, r);
    chk("R2 hi readback", r, hi);
    write(A_LO, lo);
    chk({req, " R3 port fields"}, port_word(), exp_lo(lo, 1'b1));
    chk("R3 dest id", 32'(did), 32'(hi[31:24]));
    chk({req, " mask"}, 32'(mask), 32'(exp_mask(lo[19:18], hi[31:24])));
    read(A_LO, r);
    chk("R11 R4 lo read busy", r, exp_lo(lo, 1'b1));
  endtask

  initial begin
    logic [31:0] r, hi, lo, lo2, snap;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", 32'(valid), 32'd0);
    read(A_LO, r); chk("R1 lo", r, 32'd0);
    read(A_HI, r); chk("R1 hi", r, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 unmapped write and read
    write(12'h320, 32'hFFFF_FFFF);
    chk("R12 no launch", 32'(valid), 32'd0);
    read(12'h320, r); chk("R12 unmapped read", r, 32'd0);
    read(A_HI, r); chk("R12 hi untouched", r, 32'd0);
    read(A_LO, r); chk("R12 lo untouched", r, 32'd0);

    // startup message: vector = start address / page size
    send_check(32'h0300_0000, 32'h0000_0600 | (32'h0000_9000 >> 12), "R7 startup");
    chk("R3 startup vector", 32'(vec), 32'h09);
    handshake();
    chk("R4 valid cleared", 32'(valid), 32'd0);
    read(A_LO, r); chk("R4 busy clear", r, 32'h0000_0609);

    // INIT assert/deassert, all including self
    send_check(32'h0, 32'h0008_C500, "R9 all");
    chk("R9 all mask", 32'(mask), 32'hF);
    handshake();
    send_check(32'h0, 32'h000C_8500, "R10 others");
    chk("R10 others mask", 32'(mask), 32'hB);
    handshake();
    send_check(32'h0500_0000, 32'h0004_0011, "R8 self");
    chk("R8 self mask", 32'(mask), 32'h4);
    handshake();
    send_check(32'h0700_0000, 32'h0000_0022, "R7 out of range");
    chk("R7 empty mask", 32'(mask), 32'h0);
    handshake();

    // R6 ignored write while busy, then no second launch
    send_check(32'h0100_0000, 32'h0000_0033, "R7 field");
    write(A_LO, 32'h000C_C544);
    chk("R6 fields held", port_word(), exp_lo(32'h0000_0033, 1'b1));
    chk("R6 valid held", 32'(valid), 32'd1);
    handshake();
    chk("R6 no relaunch", 32'(valid), 32'd0);
    read(A_LO, r); chk("R6 lo unchanged", r, 32'h0000_0033);

    for (int i = 0; i < 200; i++) begin
      hi = $urandom;
      hi[31:24] = 8'($urandom_range(0, 7));
      lo = $urandom;
      send_check(hi, lo, "R7 R8 R9 R10 random");
      snap = port_word();
      if ($urandom_range(0, 2) == 0) begin
        lo2 = $urandom;
        write(A_LO, lo2);
        chk("R6 random ignored", port_word(), snap);
      end
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        @(negedge clk);
        chk("R5 hold", port_word(), snap);
      end
      handshake();
      chk("R4 random clear", 32'(valid), 32'd0);
      read(A_LO, r); chk("R11 random lo", r, exp_lo(lo, 1'b0));
    end
    report();
  end
endmodule